// File: doc/BRIEF.md
# Tagged Receive Byte Queue

This block sits between a serial frame receiver and whatever drains received data, either a processor reading a data register or a DMA engine. Each slot holds one received byte together with three status tags: end of frame, checksum error, and abort/framing error. The receiver pushes complete entries. The reader pops them from the head in arrival order.

The receiver cannot be stalled. The input handshake is valid/ready, but `in_ready` is only advisory. It is low exactly when all slots are occupied. A push presented while full is accepted only if a pop completes on the same edge. Otherwise the byte is discarded and a sticky overrun flag rises. On the output side `out_valid` is high whenever the queue is non-empty. A pop completes on a rising edge with `out_valid` and `out_ready` both high. `out_data` holds the head entry and stays stable until it is popped.

Two control outputs serve the reader. `svc_req` is a level request raised while the fill level lies in a middle band. `eof_irq` is raised while a frame-ending entry sits among the oldest few occupied slots, so the reader knows a whole frame tail can be collected from the head.

Top module: `rxtag_fifo`

## Requirements
- R1: After reset, `level` is 0, `out_valid`, `svc_req`, `ovr_irq` and `eof_irq` are 0, and `in_ready` is 1.
- R2: Entries leave in the order they were accepted with all 11 bits unchanged: bits [7:0] are the byte, bit 8 marks end of frame, bit 9 marks a checksum error, and bit 10 marks abort or framing error.
- R3: The queue holds 12 entries. `level` reports the occupancy, and `in_ready` is 0 exactly when `level` is 12.
- R4: `svc_req` is 1 exactly when `level` is from 4 to 8 inclusive.
- R5: A push while full with no pop on the same edge is discarded. `level` and the stored contents do not change, and `ovr_irq` becomes 1 on the following cycle.
- R6: A push and a pop on the same edge while full are both accepted. `level` stays 12 and `ovr_irq` is not set.
- R7: `ovr_irq` stays 1 until a cycle with `ovr_clr` high clears it. When a discarding push and `ovr_clr` coincide, the flag stays 1.
- R8: `eof_irq` is 1 exactly when one of the oldest min(4, `level`) entries has bit 8 set.
- R9: A pop request (`out_ready` high) while empty has no effect, and `level` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receiver presents an entry |
| in_ready | output | 1 | Space available (advisory; receiver cannot stall) |
| in_data | input | 11 | Entry: tags in [10:8], byte in [7:0] |
| out_valid | output | 1 | Head entry present |
| out_ready | input | 1 | Reader takes the head entry |
| out_data | output | 11 | Head entry |
| level | output | 4 | Current occupancy |
| svc_req | output | 1 | Service request for the mid-fill band |
| ovr_irq | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clear strobe for the overrun flag |
| eof_irq | output | 1 | Frame end among the oldest entries |

## Verification
The hardest case to reach is a frame-ending entry that starts outside the four-entry head window and moves into it as the reader pops. The stimulus pushes six entries with the end mark on the last one, checks that `eof_irq` stays low, and then pops one entry at a time until the mark reaches the fourth slot. A second hard case is the full-queue boundary. The queue is filled to 12 and then driven three ways: a lone push, a push paired with a pop, and a discarding push in the same cycle as the clear strobe. The scoreboard checks that no dropped byte ever appears at the output.

// File: rtl/rxtag_pkg.sv
package rxtag_pkg;
  localparam int BYTE_W = 8;
  localparam int ENTRY_W = BYTE_W + 3;

  typedef struct packed {
    logic              abort_err;
    logic              crc_err;
    logic              eof;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxtag_ptrs.sv
module rxtag_ptrs #(
  parameter int DEPTH = 12,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_ok,
  input  logic             pop_ok,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic [CNT_W-1:0] level
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_idx <= bump(wr_idx);
      if (pop_ok)  rd_idx <= bump(rd_idx);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rxtag_store.sv
module rxtag_store
  import rxtag_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  rx_entry_t        wdata,
  input  logic [PTR_W-1:0] raddr,
  output rx_entry_t        rdata,
  output logic [DEPTH-1:0] eof_bits
);
  rx_entry_t slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slots[g] <= '0;
      else if (we && waddr == PTR_W'(g))
        slots[g] <= wdata;
    end
    assign eof_bits[g] = slots[g].eof;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/rxtag_eof_scan.sv
module rxtag_eof_scan #(
  parameter int DEPTH = 12,
  parameter int WIN = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] eof_bits,
  input  logic [PTR_W-1:0] rd_idx,
  input  logic [CNT_W-1:0] level,
  output logic             hit
);
  logic [WIN-1:0] near;

  for (genvar k = 0; k < WIN; k++) begin : g_win
    logic [PTR_W:0] raw;
    logic [PTR_W:0] wrapped;
    always_comb begin
      raw = {1'b0, rd_idx} + (PTR_W+1)'(k);
      wrapped = (raw >= (PTR_W+1)'(DEPTH)) ? raw - (PTR_W+1)'(DEPTH) : raw;
      near[k] = (level > CNT_W'(k)) && eof_bits[wrapped[PTR_W-1:0]];
    end
  end

  assign hit = |near;
endmodule

// File: rtl/rxtag_fifo.sv
module rxtag_fifo
  import rxtag_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int SVC_LO = 4,
  parameter int SVC_HI = 8,
  parameter int EOF_WIN = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ENTRY_W-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ENTRY_W-1:0] out_data,
  output logic [CNT_W-1:0]   level,
  output logic               svc_req,
  output logic               ovr_irq,
  input  logic               ovr_clr,
  output logic               eof_irq
);
  logic [PTR_W-1:0] wr_idx, rd_idx;
  logic [DEPTH-1:0] eof_bits;
  logic             full, pop_ok, push_ok, drop;
  rx_entry_t        head;

  assign full      = (level == CNT_W'(DEPTH));
  assign in_ready  = !full;
  assign out_valid = (level != '0);
  assign pop_ok    = out_valid && out_ready;
  assign push_ok   = in_valid && (!full || pop_ok);
  assign drop      = in_valid && full && !pop_ok;

  rxtag_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .level(level)
  );

  rxtag_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(push_ok), .waddr(wr_idx),
    .wdata(rx_entry_t'(in_data)), .raddr(rd_idx), .rdata(head),
    .eof_bits(eof_bits)
  );

  rxtag_eof_scan #(.DEPTH(DEPTH), .WIN(EOF_WIN)) u_scan (
    .eof_bits(eof_bits), .rd_idx(rd_idx), .level(level), .hit(eof_irq)
  );

  assign out_data = head;
  assign svc_req  = (level >= CNT_W'(SVC_LO)) && (level <= CNT_W'(SVC_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovr_irq <= 1'b0;
    else if (drop)
      ovr_irq <= 1'b1;
    else if (ovr_clr)
      ovr_irq <= 1'b0;
  end
endmodule

// File: rtl/rxtag_fifo_chk.sv
module rxtag_fifo_chk #(
  parameter int DEPTH = 12,
  parameter int SVC_HI = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CNT_W-1:0] level,
  input logic             svc_req,
  input logic             ovr_irq,
  input logic             ovr_clr,
  input logic             eof_irq
);
  AST_READY_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CNT_W'(DEPTH)) == !in_ready); // R3
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (level == $past(level)) || (level == $past(level) + CNT_W'(1)) ||
    (level + CNT_W'(1) == $past(level))); // R3
  AST_SVC_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> (in_ready && out_valid)); // R4
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !out_ready) |=> (ovr_irq && level == CNT_W'(DEPTH))); // R5
  AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && out_ready && !ovr_irq) |=> !ovr_irq); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_irq && !ovr_clr) |=> ovr_irq); // R7
  AST_EMPTY_NO_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !eof_irq); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> (level == '0)); // R9
  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH)); // R3
endmodule

bind rxtag_fifo rxtag_fifo_chk #(.DEPTH(DEPTH), .SVC_HI(SVC_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .level(level),
  .svc_req(svc_req), .ovr_irq(ovr_irq), .ovr_clr(ovr_clr), .eof_irq(eof_irq)
);

// File: tb/sim_rxtag_fifo.sv
`timescale 1ns/1ps
module sim_rxtag_fifo;
  localparam int CAP = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0, ovr_clr = 1'b0;
  logic [10:0] in_data = '0;
  logic        in_ready, out_valid, svc_req, ovr_irq, eof_irq;
  logic [10:0] out_data;
  logic [3:0]  level;

  int nchk = 0;
  int nfail = 0;
  logic [10:0] exp_q[$];
  logic exp_ovr = 1'b0;

  always #5 clk = ~clk;

  rxtag_fifo u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .level(level), .svc_req(svc_req),
    .ovr_irq(ovr_irq), .ovr_clr(ovr_clr), .eof_irq(eof_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: a pop handshake seen mid-cycle completes at the next edge.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0)
        check("R2 unexpected output", int'(out_data), -1);
      else
        check("R2 order/tags", int'(out_data), int'(exp_q.pop_front()));
    end
  end

  // Driver: one cycle of stimulus, model updated per the requirements.
  task automatic step(input logic v, input logic [10:0] d, input logic r, input logic clr);
    int sz;
    @(posedge clk); #2;
    in_valid = v; in_data = d; out_ready = r; ovr_clr = clr;
    sz = exp_q.size();
    if (v && sz == CAP && !(r && sz > 0))
      exp_ovr = 1'b1;
    else begin
      if (clr) exp_ovr = 1'b0;
      if (v) exp_q.push_back(d);
    end
  endtask

  task automatic idle();
    logic e;
    int sz;
    @(posedge clk); #2;
    in_valid = 0; out_ready = 0; ovr_clr = 0; in_data = '0;
    sz = exp_q.size();
    e = 1'b0;
    for (int k = 0; k < 4 && k < sz; k++) e |= exp_q[k][8];
    check("R3 level", int'(level), sz);
    check("R3 in_ready", int'(in_ready), int'(sz != CAP));
    check("R4 svc_req", int'(svc_req), int'(sz >= 4 && sz <= 8));
    check("R8 eof_irq", int'(eof_irq), int'(e));
    check("R7 ovr_irq", int'(ovr_irq), int'(exp_ovr));
  endtask

  initial begin
    #(200000 * 10);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    check("R1 level", int'(level), 0);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 svc_req", int'(svc_req), 0);
    check("R1 ovr_irq", int'(ovr_irq), 0);
    check("R1 eof_irq", int'(eof_irq), 0);

    step(0, '0, 1, 0); idle();
    check("R9 empty pop", int'(level), 0);

    // six entries, tags on several, frame end on the sixth
    for (int i = 0; i < 6; i++) begin
      logic [10:0] w;
      w = {3'b000, 8'h10 + 8'(i)};
      if (i == 1) w[9] = 1'b1;
      if (i == 2) w[10] = 1'b1;
      if (i == 5) w[8] = 1'b1;
      step(1, w, 0, 0); idle();
    end
    check("R8 eof outside window", int'(eof_irq), 0);
    step(0, '0, 1, 0); idle();
    check("R8 eof at slot 5", int'(eof_irq), 0);
    step(0, '0, 1, 0); idle();
    check("R8 eof enters window", int'(eof_irq), 1);

    for (int i = 0; i < 8; i++) begin
      step(1, {3'b000, 8'h40 + 8'(i)}, 0, 0); idle();
    end
    check("R3 full ready low", int'(in_ready), 0);

    step(1, 11'h0AA, 0, 0); idle();
    check("R5 overrun set", int'(ovr_irq), 1);
    check("R5 level kept", int'(level), 12);

    step(0, '0, 0, 1); idle();
    check("R7 cleared", int'(ovr_irq), 0);

    step(1, 11'h2BB, 1, 0); idle();
    check("R6 no overrun", int'(ovr_irq), 0);
    check("R6 level full", int'(level), 12);

    step(1, 11'h0CC, 0, 0); idle();
    for (int i = 0; i < 3; i++) idle();
    check("R7 sticky", int'(ovr_irq), 1);
    step(1, 11'h0DD, 0, 1); idle();
    check("R7 set wins", int'(ovr_irq), 1);
    step(0, '0, 0, 1); idle();

    while (exp_q.size() > 0) begin
      step(0, '0, 1, 0); idle();
    end
    check("R2 drained", int'(out_valid), 0);
    step(0, '0, 1, 0); idle();
    check("R9 empty pop again", int'(level), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule